// File: doc/BRIEF.md
# Multi-Cycle Fixed-Point Ratio Scaler

The block multiplies an unsigned fixed-point operand by a ratio M/D and rounds the result to the nearest value. M comes from a compile-time table of multipliers and D from a compile-time table of divisors. A separate index input picks from each table on every operation. The result keeps the binary point of the operand, so its LSB has the same weight as the operand LSB.

A one-cycle pulse on `start_i` latches the operand and both indices. The product is then built with serial shift-add steps, one operand bit per cycle, LSB first. The product register is preloaded with floor(D/2), which gives round-half-up. Serial restoring division then produces one quotient bit per cycle. `done_o` is low for the whole operation. The result register changes only when an operation completes. A new start pulse during a running operation discards that operation and begins again with the current inputs.

Top module: `ratio_scaler`

## Requirements
- R1: When an operation completes, `res_o` equals floor((arg·M + floor(D/2)) / D). This is arg·M/D rounded to nearest, with exact halves rounded up.
- R2: The result is the low RES_W bits of the rounded quotient, with the LSB of `res_o` at the weight of the `arg_i` LSB. A quotient of 2^RES_W or more is truncated silently.
- R3: `msel_i` = k selects multiplier table entry k, and `dsel_i` = k selects divisor table entry k. Entry k sits at bits [k·W+W-1 : k·W] of the packed table parameter, so entry 0 is in the low bits. An index past the table size selects entry 0.
- R4: `done_o` is high when idle and goes low in the cycle after a start pulse. It rises again exactly ARG_W + PW clock edges after the capture edge, where PW = ARG_W + max(MUL_W, DIV_W) + 1. With the defaults this is 25 edges.
- R5: A start pulse during a running operation aborts it, with no result written for it, and restarts from the inputs present on that start cycle.
- R6: `res_o` keeps its value from one completion to the next, including while an operation runs.
- R7: While `rst_ni` is low, the block is idle with `done_o` = 1 and `res_o` = 0.
- R8: `arg_i`, `msel_i` and `dsel_i` are sampled only on the start cycle. Changing them during an operation does not change its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle start pulse; also restarts a running operation |
| arg_i | input | ARG_W | Unsigned fixed-point operand |
| msel_i | input | MSEL_W | Multiplier table index |
| dsel_i | input | DSEL_W | Divisor table index |
| done_o | output | 1 | High when no operation is running |
| res_o | output | RES_W | Last completed scaled result |

## Verification
On every cycle, the assertions check the following:
- `done_o` drops after a start pulse, and a start puts the engine back to its first multiply step.
- The step counter stays within its phase.
- The partial remainder stays below the latched divisor.
- `res_o` holds still except on the final division step.

Only the bench scenarios can show the arithmetic itself. The scoreboard checks the rounded quotient, including ties and truncation, the table selection, the exact latency, aborted operations and inputs changed in mid-run, against values computed from the ratio formula.

// File: rtl/ratio_scaler_pkg.sv
package ratio_scaler_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_DIV  = 2'd2
  } scaler_state_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rs_table.sv
module rs_table #(
  parameter int unsigned NUM   = 4,
  parameter int unsigned VAL_W = 8,
  parameter logic [NUM*VAL_W-1:0] TABLE = '0,
  localparam int unsigned SEL_W = ratio_scaler_pkg::idx_width(NUM)
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [VAL_W-1:0] val_o
);
  logic [VAL_W-1:0] entry [NUM];

  for (genvar k = 0; k < NUM; k++) begin : g_entry
    assign entry[k] = TABLE[k*VAL_W +: VAL_W];
  end

  always_comb begin
    val_o = entry[0];
    for (int k = 0; k < NUM; k++) begin
      if (32'(sel_i) == k) val_o = entry[k];
    end
  end
endmodule

// File: rtl/rs_mul_step.sv
module rs_mul_step #(
  parameter int unsigned PW = 17
) (
  input  logic          bit_i,
  input  logic [PW-1:0] acc_i,
  input  logic [PW-1:0] mcand_i,
  output logic [PW-1:0] acc_o
);
  assign acc_o = bit_i ? (acc_i + mcand_i) : acc_i;
endmodule

// File: rtl/rs_div_step.sv
module rs_div_step #(
  parameter int unsigned PW    = 17,
  parameter int unsigned DIV_W = 8
) (
  input  logic [DIV_W-1:0] rem_i,
  input  logic [PW-1:0]    quot_i,
  input  logic [DIV_W-1:0] div_i,
  output logic [DIV_W-1:0] rem_o,
  output logic [PW-1:0]    quot_o
);
  logic [DIV_W:0] rem_sh;
  logic [DIV_W:0] diff;
  logic           fits;

  assign rem_sh = {rem_i, quot_i[PW-1]};
  assign diff   = rem_sh - {1'b0, div_i};
  assign fits   = rem_sh >= {1'b0, div_i};
  assign rem_o  = fits ? diff[DIV_W-1:0] : rem_sh[DIV_W-1:0];
  assign quot_o = {quot_i[PW-2:0], fits};
endmodule

// File: rtl/ratio_scaler.sv
module ratio_scaler #(
  parameter int unsigned ARG_W   = 8,
  parameter int unsigned RES_W   = 10,
  parameter int unsigned NUM_MUL = 4,
  parameter int unsigned NUM_DIV = 4,
  parameter int unsigned MUL_W   = 8,
  parameter int unsigned DIV_W   = 8,
  parameter logic [NUM_MUL*MUL_W-1:0] MUL_TABLE = {8'd7, 8'd5, 8'd3, 8'd1},
  parameter logic [NUM_DIV*DIV_W-1:0] DIV_TABLE = {8'd7, 8'd3, 8'd2, 8'd1},
  localparam int unsigned MSEL_W = ratio_scaler_pkg::idx_width(NUM_MUL),
  localparam int unsigned DSEL_W = ratio_scaler_pkg::idx_width(NUM_DIV)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ARG_W-1:0]  arg_i,
  input  logic [MSEL_W-1:0] msel_i,
  input  logic [DSEL_W-1:0] dsel_i,
  output logic              done_o,
  output logic [RES_W-1:0]  res_o
);
  import ratio_scaler_pkg::*;

  localparam int unsigned PW        = ARG_W + max2(MUL_W, DIV_W) + 1;
  localparam int unsigned MAX_STEPS = max2(ARG_W, PW);
  localparam int unsigned CNT_W     = $clog2(MAX_STEPS + 1);
  localparam logic [CNT_W-1:0] MUL_LAST = CNT_W'(ARG_W - 1);
  localparam logic [CNT_W-1:0] DIV_LAST = CNT_W'(PW - 1);

  scaler_state_e    state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ARG_W-1:0] arg_q;
  logic [PW-1:0]    mcand_q;
  logic [PW-1:0]    work_q;   // product in MUL, dividend/quotient in DIV
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] rem_q;
  logic [RES_W-1:0] res_q;

  logic [MUL_W-1:0] mul_val;
  logic [DIV_W-1:0] div_val;
  logic [PW-1:0]    acc_nxt;
  logic [PW-1:0]    quot_nxt;
  logic [DIV_W-1:0] rem_nxt;
  logic             final_step;

  rs_table #(.NUM(NUM_MUL), .VAL_W(MUL_W), .TABLE(MUL_TABLE)) u_mul_tab (
    .sel_i(msel_i), .val_o(mul_val)
  );

  rs_table #(.NUM(NUM_DIV), .VAL_W(DIV_W), .TABLE(DIV_TABLE)) u_div_tab (
    .sel_i(dsel_i), .val_o(div_val)
  );

  rs_mul_step #(.PW(PW)) u_mul_step (
    .bit_i(arg_q[0]), .acc_i(work_q), .mcand_i(mcand_q), .acc_o(acc_nxt)
  );

  rs_div_step #(.PW(PW), .DIV_W(DIV_W)) u_div_step (
    .rem_i(rem_q), .quot_i(work_q), .div_i(div_q),
    .rem_o(rem_nxt), .quot_o(quot_nxt)
  );

  assign final_step = (state_q == ST_DIV) && (cnt_q == DIV_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      arg_q   <= '0;
      mcand_q <= '0;
      work_q  <= '0;
      div_q   <= '0;
      rem_q   <= '0;
      res_q   <= '0;
    end else if (start_i) begin
      state_q <= ST_MUL;
      cnt_q   <= '0;
      arg_q   <= arg_i;
      mcand_q <= PW'(mul_val);
      work_q  <= PW'(div_val >> 1);  // rounding offset
      div_q   <= div_val;
      rem_q   <= '0;
    end else begin
      unique case (state_q)
        ST_MUL: begin
          work_q  <= acc_nxt;
          arg_q   <= arg_q >> 1;
          mcand_q <= mcand_q << 1;
          if (cnt_q == MUL_LAST) begin
            state_q <= ST_DIV;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DIV: begin
          work_q <= quot_nxt;
          rem_q  <= rem_nxt;
          if (final_step) begin
            res_q   <= quot_nxt[RES_W-1:0];
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: cnt_q <= '0;
      endcase
    end
  end

  assign done_o = (state_q == ST_IDLE);
  assign res_o  = res_q;

  // R4
  done_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o);

  // R5
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_q == ST_MUL) && (cnt_q == '0));

  // R4
  step_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_MUL) -> (cnt_q <= MUL_LAST)) &&
    ((state_q == ST_DIV) -> (cnt_q <= DIV_LAST)));

  // R1
  rem_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DIV) |-> (rem_q < div_q));

  // R6
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !final_step |=> $stable(res_o));
endmodule

// File: tb/ratio_scaler_test.sv
module ratio_scaler_test;
  localparam int CLK_PERIOD = 10;
  localparam int ARG_W = 8;
  localparam int RES_W = 10;
  localparam int PW    = ARG_W + 8 + 1;
  localparam int LAT   = ARG_W + PW;
  localparam int MULS [4] = '{1, 3, 5, 7};
  localparam int DIVS [4] = '{1, 2, 3, 7};

  typedef struct {
    int unsigned  exp_res;
    longint       exp_cyc;
    string        tag;
  } item_t;

  logic             clk = 0;
  logic             rst_n = 0;
  logic             start = 0;
  logic [ARG_W-1:0] arg = '0;
  logic [1:0]       msel = '0;
  logic [1:0]       dsel = '0;
  logic             done;
  logic [RES_W-1:0] res;

  int     checks = 0;
  int     errors = 0;
  longint cyc = 0;
  bit     finished = 0;
  item_t  sb [$];

  ratio_scaler #(
    .ARG_W(ARG_W), .RES_W(RES_W), .NUM_MUL(4), .NUM_DIV(4),
    .MUL_W(8), .DIV_W(8),
    .MUL_TABLE({8'd7, 8'd5, 8'd3, 8'd1}),
    .DIV_TABLE({8'd7, 8'd3, 8'd2, 8'd1})
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .arg_i(arg),
    .msel_i(msel), .dsel_i(dsel), .done_o(done), .res_o(res)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int unsigned model(int a, int m, int d);
    longint q = (longint'(a) * m + d / 2) / d;
    return int'(q % (64'd1 << RES_W));
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drives one start pulse; push=0 marks an operation expected to be aborted.
  task automatic start_op(int a, int mi, int di, bit push, string tag);
    item_t it;
    @(negedge clk);
    arg = ARG_W'(a); msel = 2'(mi); dsel = 2'(di); start = 1;
    if (push) begin
      it.exp_res = model(a, MULS[mi], DIVS[di]);
      it.exp_cyc = cyc + 1 + LAT;
      it.tag = tag;
      sb.push_back(it);
    end
    @(negedge clk);
    start = 0;
    check(done == 0, "R4 done low after start", done, 0);
    arg = ~arg; msel = msel + 1; dsel = dsel + 2;  // R8 disturb inputs
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (sb.size() != 0 || !done);
  endtask

  // Monitor: pops on each completion, also watches res stability (R6).
  initial begin
    logic             prev_done = 1;
    logic [RES_W-1:0] prev_res = '0;
    item_t            it;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (!prev_done && done) begin
          if (sb.size() == 0) begin
            check(0, "R5 unexpected completion", res, -1);
          end else begin
            it = sb.pop_front();
            check(res == it.exp_res, it.tag, res, it.exp_res);
            check(cyc == it.exp_cyc, "R4 latency", cyc, it.exp_cyc);
          end
        end else if (res != prev_res) begin
          check(0, "R6 res changed without completion", res, prev_res);
        end
      end
      prev_done = done;
      prev_res = res;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7 reset state
    check(done == 1, "R7 done in reset", done, 1);
    check(res == 0, "R7 res in reset", res, 0);
    rst_n = 1;
    @(negedge clk);
    check(done == 1, "R7 idle after reset", done, 1);

    start_op(10, 1, 3, 1, "R1 10*3/7");  wait_idle();
    start_op(5, 0, 1, 1, "R1 tie 5/2");   wait_idle();
    start_op(7, 1, 1, 1, "R1 tie 21/2");  wait_idle();
    start_op(1, 0, 2, 1, "R1 1/3 down");  wait_idle();
    start_op(2, 0, 2, 1, "R1 2/3 up");    wait_idle();
    start_op(0, 3, 3, 1, "R1 zero arg");  wait_idle();
    start_op(255, 3, 0, 1, "R2 truncation 255*7"); wait_idle();
    start_op(200, 2, 0, 1, "R2 LSB weight 200*5"); wait_idle();
    for (int mi = 0; mi < 4; mi++) begin
      for (int di = 0; di < 4; di++) begin
        start_op(37 + mi * 50 + di, mi, di, 1, "R3 table select");
        wait_idle();
      end
    end
    // R5 restart mid-run: first op never reports
    start_op(100, 3, 3, 0, "aborted");
    repeat (5) @(negedge clk);
    start_op(9, 2, 2, 1, "R5 restart result");
    wait_idle();
    // R5 restart in the division phase
    start_op(250, 1, 2, 0, "aborted");
    repeat (ARG_W + 4) @(negedge clk);
    start_op(77, 3, 1, 1, "R5 restart in divide");
    wait_idle();
    // R6 result held across idle gap
    repeat (10) @(negedge clk);
    check(res == RES_W'(model(77, 7, 2)), "R6 res held while idle", res, model(77, 7, 2));
    // R8 random ops with inputs disturbed after start
    for (int n = 0; n < 40; n++) begin
      start_op(int'($urandom_range(0, 255)), int'($urandom_range(0, 3)),
               int'($urandom_range(0, 3)), 1, "R8 captured inputs");
      wait_idle();
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule